// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces a system reset from two causes: a supply-good flag that is already synchronous to the block clock, and an active-low manual reset request that may come from a pushbutton or from other logic. Reset is driven for as long as either cause is present. Once both have cleared, reset is held for a further fixed hold period counted in cycles of a free-running clock, and then released.

A new cause that appears while the hold period is running abandons the count. The full period starts over once that cause clears. The hold period is much longer than any contact bounce, so a mechanical switch can drive the manual input without a separate debouncer. The manual input is first passed through a synchroniser. A low level on it then counts only once it has lasted a minimum number of sampled cycles, so short glitches are ignored. Two outputs carry the same reset in opposite polarities.

Top module: `supply_reset_gen`

## Requirements
- R1: While `supply_ok_i` is low, `rst_o` is 1 from the first clock edge that samples it low and stays 1.
- R2: After the last clock edge that samples a reset cause, `rst_o` stays 1 for exactly the effective hold period in clock cycles and falls on the next edge.
- R3: A supply drop during a running hold period restarts it: after the supply recovers, a full effective hold period elapses before release.
- R4: A qualified low on `mr_n_i` asserts reset. After `mr_n_i` returns high, the synchroniser adds two cycles and then the full hold period follows, so `rst_o` is 1 for hold+2 edges after the release and 0 after the next edge.
- R5: The effective hold period is the larger of `HOLD_CYCLES` and `MIN_HOLD_CYCLES`. A hold parameter below the minimum never shortens the reset.
- R6: `rst_n_o` is always the complement of `rst_o`.
- R7: A low pulse on `mr_n_i` that is sampled low for fewer than `MR_MIN_CYCLES` synchronised cycles has no effect on either output. A pulse of exactly `MR_MIN_CYCLES` cycles is recognised.
- R8: While `por_i` is high, `rst_o` is 1 and the hold counter is cleared. After `por_i` falls, reset stays asserted until the causes clear and a full hold period has run.
- R9: A qualified manual reset during a running hold period restarts it, in the same way as a supply drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock that times the hold period |
| por_i | input | 1 | Asynchronous power-on reset, active high |
| supply_ok_i | input | 1 | Synchronous supply-good flag, high when the supply is above threshold |
| mr_n_i | input | 1 | Asynchronous manual reset request, active low |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |

## Verification
The assertions assume that `supply_ok_i` changes only away from the active clock edge, and that `por_i` is applied before any property is evaluated. The bench changes every input on the falling clock edge and holds `por_i` high for several cycles at the start. Manual-reset pulses are whole numbers of clock cycles, so their sampled width is known exactly: both the width just below the qualifying length and the qualifying length itself are applied. The bench uses short hold periods, so that every cycle of each hold window can be checked.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    // Hold timer states: cause present, counting out the hold, released.
    typedef enum logic [1:0] {
        HS_ASSERT = 2'd0,
        HS_COUNT  = 2'd1,
        HS_RUN    = 2'd2
    } hold_state_e;

    // Reset causes seen by the hold timer on a given cycle.
    typedef struct packed {
        logic supply_bad;
        logic manual_req;
    } rst_cause_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/sr_sync_chain.sv
module sr_sync_chain #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q[0] <= RESET_VAL;
        else       chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or posedge por_i) begin
            if (por_i) chain_q[s] <= RESET_VAL;
            else       chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sr_mr_qualifier.sv
module sr_mr_qualifier #(
    parameter int unsigned MIN_CYCLES = 4
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic sync_low_i,
    output logic req_o
);
    import sup_rst_pkg::*;

    localparam int unsigned QW = cnt_width(MIN_CYCLES);
    localparam logic [QW-1:0] LAST = QW'(MIN_CYCLES - 1);

    logic [QW-1:0] run_q;

    // Count consecutive low samples, saturating at the qualifying length.
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)              run_q <= '0;
        else if (!sync_low_i)   run_q <= '0;
        else if (run_q != LAST) run_q <= run_q + 1'b1;
    end

    assign req_o = sync_low_i && (run_q == LAST);

    if (MIN_CYCLES > 1) begin : g_chk
        // A request can only begin after the input has already been low.
        p_qual_needs_low_r7: assert property (@(posedge clk_i) disable iff (por_i)
            $rose(req_o) |-> $past(sync_low_i));
    end
endmodule

// File: rtl/sr_hold_timer.sv
module sr_hold_timer #(
    parameter int unsigned HOLD = 10
) (
    input  logic                    clk_i,
    input  logic                    por_i,
    input  sup_rst_pkg::rst_cause_t cause_i,
    output logic                    rst_active_o
);
    import sup_rst_pkg::*;

    localparam int unsigned CW = cnt_width(HOLD);
    localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

    hold_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic          any_cause;

    assign any_cause = cause_i.supply_bad | cause_i.manual_req;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            state_q <= HS_ASSERT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                HS_ASSERT: begin
                    cnt_q <= LOAD;
                    if (!any_cause) state_q <= HS_COUNT;
                end
                HS_COUNT: begin
                    if (any_cause) begin
                        state_q <= HS_ASSERT;
                        cnt_q   <= LOAD;
                    end else if (cnt_q == '0) begin
                        state_q <= HS_RUN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                HS_RUN: begin
                    if (any_cause) begin
                        state_q <= HS_ASSERT;
                        cnt_q   <= LOAD;
                    end
                end
                default: state_q <= HS_ASSERT;
            endcase
        end
    end

    assign rst_active_o = (state_q != HS_RUN);

    p_release_at_zero_r2: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(rst_active_o) |-> $past(state_q == HS_COUNT && cnt_q == '0));

    p_full_reload_r3: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == HS_COUNT && $past(state_q) == HS_ASSERT) |-> cnt_q == LOAD);

    p_count_steps_r5: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == HS_COUNT && $past(state_q) == HS_COUNT) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
    parameter int unsigned HOLD_CYCLES     = 10_000_000,
    parameter int unsigned MIN_HOLD_CYCLES = 7_000_000,
    parameter int unsigned MR_MIN_CYCLES   = 25,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic supply_ok_i,
    input  logic mr_n_i,
    output logic rst_o,
    output logic rst_n_o
);
    import sup_rst_pkg::*;

    localparam int unsigned EFF_HOLD = max_u(HOLD_CYCLES, MIN_HOLD_CYCLES);

    logic       mr_n_sync;
    logic       mr_req;
    logic       rst_active;
    rst_cause_t cause;

    sr_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_mr_sync (
        .clk_i (clk_i),
        .por_i (por_i),
        .d_i   (mr_n_i),
        .q_o   (mr_n_sync)
    );

    sr_mr_qualifier #(.MIN_CYCLES(MR_MIN_CYCLES)) u_mr_qual (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .sync_low_i (!mr_n_sync),
        .req_o      (mr_req)
    );

    assign cause.supply_bad = !supply_ok_i;
    assign cause.manual_req = mr_req;

    sr_hold_timer #(.HOLD(EFF_HOLD)) u_hold (
        .clk_i        (clk_i),
        .por_i        (por_i),
        .cause_i      (cause),
        .rst_active_o (rst_active)
    );

    assign rst_o   = rst_active;
    assign rst_n_o = !rst_active;

    p_supply_bad_r1: assert property (@(posedge clk_i) disable iff (por_i)
        !supply_ok_i |=> rst_o);

    p_manual_asserts_r4: assert property (@(posedge clk_i) disable iff (por_i)
        mr_req |=> rst_o);

    p_por_asserted_r8: assert property (@(posedge clk_i)
        $past(por_i) |-> rst_o);
endmodule

// File: tb/supply_reset_gen_tb_top.sv
module supply_reset_gen_tb_top;
    localparam int unsigned H_MAIN  = 40;
    localparam int unsigned H_CLAMP = 25;   // max(10, 25)
    localparam int unsigned MR_MIN  = 4;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic supply_ok = 1'b0;
    logic mr_n = 1'b1;
    logic rst_a, rst_n_a, rst_b, rst_n_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    supply_reset_gen #(.HOLD_CYCLES(H_MAIN), .MIN_HOLD_CYCLES(30),
                       .MR_MIN_CYCLES(MR_MIN)) dut_i (
        .clk_i(clk), .por_i(por), .supply_ok_i(supply_ok), .mr_n_i(mr_n),
        .rst_o(rst_a), .rst_n_o(rst_n_a));

    supply_reset_gen #(.HOLD_CYCLES(10), .MIN_HOLD_CYCLES(H_CLAMP),
                       .MR_MIN_CYCLES(MR_MIN)) dut_clamp_i (
        .clk_i(clk), .por_i(por), .supply_ok_i(supply_ok), .mr_n_i(mr_n),
        .rst_o(rst_b), .rst_n_o(rst_n_b));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_pol(input string tag);
        chk(rst_n_a, ~rst_a, {tag, " R6 main polarity"});
        chk(rst_n_b, ~rst_b, {tag, " R6 clamp polarity"});
    endtask

    // Reset is expected high for edges 1..hold+off after the cause clears, low after.
    task automatic check_window(input int off, input string tag);
        for (int i = 1; i <= int'(H_MAIN) + off + 1; i++) begin
            step(1);
            chk(rst_a, (i <= int'(H_MAIN) + off), {tag, " main"});
            chk(rst_b, (i <= int'(H_CLAMP) + off), {tag, " R5 clamp"});
            chk_pol(tag);
        end
    endtask

    task automatic t_power_on();
        step(3);
        chk(rst_a, 1'b1, "R8 por main");
        chk(rst_n_a, 1'b0, "R8 R6 por main n");
        chk(rst_b, 1'b1, "R8 por clamp");
        por = 1'b0;
        step(6);
        chk(rst_a, 1'b1, "R8 R1 after por supply low");
        chk(rst_b, 1'b1, "R8 R1 after por supply low clamp");
    endtask

    task automatic t_supply_release();
        supply_ok = 1'b1;
        check_window(0, "R2 supply release");
    endtask

    task automatic t_brownout();
        supply_ok = 1'b0;
        step(1);
        chk(rst_a, 1'b1, "R1 drop asserts");
        chk(rst_b, 1'b1, "R1 drop asserts clamp");
        step(5);
        chk(rst_a, 1'b1, "R1 held while low");
        supply_ok = 1'b1;
        step(15);
        chk(rst_a, 1'b1, "R3 mid hold");
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        check_window(0, "R3 restart after brownout");
    endtask

    task automatic t_mr_short();
        mr_n = 1'b0;
        step(MR_MIN - 1);
        mr_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step(1);
            chk(rst_a, 1'b0, "R7 short pulse ignored");
            chk(rst_b, 1'b0, "R7 short pulse ignored clamp");
        end
    endtask

    task automatic t_mr_exact();
        mr_n = 1'b0;
        step(MR_MIN);
        mr_n = 1'b1;
        step(1);
        chk(rst_a, 1'b0, "R7 exact pulse not yet");
        // After edge 2 from release: asserted, then hold+2 window overall.
        for (int i = 2; i <= int'(H_MAIN) + 3; i++) begin
            step(1);
            chk(rst_a, (i <= int'(H_MAIN) + 2), "R7 R4 exact pulse window");
            chk(rst_b, (i <= int'(H_CLAMP) + 2), "R7 R5 exact pulse clamp");
            chk_pol("R7");
        end
    endtask

    task automatic t_mr_hold();
        mr_n = 1'b0;
        step(20);
        chk(rst_a, 1'b1, "R4 held by manual");
        chk(rst_b, 1'b1, "R4 held by manual clamp");
        mr_n = 1'b1;
        check_window(2, "R4 manual release");
    endtask

    task automatic t_mr_during_hold();
        supply_ok = 1'b0;
        step(3);
        supply_ok = 1'b1;
        step(10);
        chk(rst_a, 1'b1, "R9 in hold");
        mr_n = 1'b0;
        step(6);
        chk(rst_a, 1'b1, "R9 in hold during manual");
        mr_n = 1'b1;
        check_window(2, "R9 restart by manual");
    endtask

    initial begin
        #(100_000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_supply_release();
        t_brownout();
        t_mr_short();
        t_mr_exact();
        t_mr_hold();
        t_mr_during_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule